// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar in packed two-digit BCD. It counts seconds, minutes and hours, date, month and two-digit year. It also keeps a century value that is either 19 or 20, and a free-running 3-bit weekday. A base tick input is divided by `SUB_DIV` to form one-second steps. Each step carries through every field in the same clock edge, so the outputs never show a half-carried or illegal date. Hours count in 24-hour form or in 12-hour form with a PM flag, chosen by a mode bit that is held with the hour.

Software sets the clock through a one-beat write port using valid/ready. `wr_ready` is held high, so the port never applies back-pressure and every beat with `wr_valid` high is consumed in its cycle. A consumed beat whose fields form a legal time and date replaces all fields at once. A consumed beat whose fields are not legal is dropped and leaves the block untouched. The reset is synchronous and active high.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the block shows 12:00:00 in 12-hour mode with the PM flag clear, date 01, month 01, year 00, century 20 and weekday 0, and the sub-second phase is zero.
- R2: Seconds advance by one on the edge that registers the `SUB_DIV`-th base tick counted since reset or since the last accepted write. Earlier ticks change no visible field.
- R3: Seconds and minutes count 00 to 59 in BCD and wrap to 00. The wrap of seconds advances minutes, and the wrap of minutes advances the hour.
- R4: With the mode bit at 1, hours count 00 to 23 and the PM flag reads 0. The step from 23 to 00 ends the day.
- R5: With the mode bit at 0, hours run 12, 01, 02 … 11, and the PM flag (1 = PM) flips on each step from 11 to 12. The step from 11 PM to 12 AM ends the day.
- R6: The end of a day advances the date. The date wraps to 01 after the month's last day, using lengths 31, 28/29, 31, 30, 31, 30, 31, 31, 30, 31, 30, 31 for months 01 to 12. That wrap advances the month, and month 12 wraps to 01 and advances the year.
- R7: February has 29 days exactly when the binary value of the two-digit year is a multiple of 4, including year 00.
- R8: Year 99 wraps to 00. At that wrap a century of 19 becomes 20, and a century of 20 stays 20.
- R9: The weekday counts 0 to 6 and wraps to 0. It steps once at each end of day, whatever the date, and it does not change otherwise.
- R10: An accepted write loads every field on one edge and takes precedence over a tick in the same cycle. That tick is discarded and the sub-second phase returns to zero.
- R11: A write is dropped, leaving all fields and the phase as they were, if any of these holds: a non-BCD digit; seconds or minutes above 59; in 24-hour mode, an hour above 23; in 12-hour mode, an hour outside 01..12; a month outside 01..12; a date of 00 or past the month's length; a century other than 19 or 20; or a weekday of 7. In 24-hour mode the written PM flag is ignored and stored as 0.
- R12: Every output field always holds a legal value under the rules above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Base tick, one cycle wide; `SUB_DIV` of them make a second |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Always 1; a beat is consumed in the cycle it is valid |
| wr_sec | input | 8 | Seconds to load, BCD |
| wr_min | input | 8 | Minutes to load, BCD |
| wr_hour | input | 8 | Hour to load, BCD, in the form chosen by `wr_mode24` |
| wr_mode24 | input | 1 | 1 = 24-hour counting, 0 = 12-hour counting |
| wr_pm | input | 1 | PM flag to load in 12-hour mode |
| wr_date | input | 8 | Day of month to load, BCD |
| wr_month | input | 8 | Month to load, BCD |
| wr_year | input | 8 | Two-digit year to load, BCD |
| wr_century | input | 8 | Century to load, BCD 19 or 20 |
| wr_dow | input | 3 | Weekday to load, 0 to 6 |
| cur_sec | output | 8 | Current seconds |
| cur_min | output | 8 | Current minutes |
| cur_hour | output | 8 | Current hour |
| cur_mode24 | output | 1 | Current hour mode |
| cur_pm | output | 1 | Current PM flag |
| cur_date | output | 8 | Current day of month |
| cur_month | output | 8 | Current month |
| cur_year | output | 8 | Current two-digit year |
| cur_century | output | 8 | Current century |
| cur_dow | output | 3 | Current weekday |

## Verification
The bench builds the block with `SUB_DIV` = 2. With that value a second costs only two ticks, so a run of more than an hour of continuous seconds fits in the cycle budget, and a half-elapsed second still exists to show how writes and dropped writes affect the phase. With it, the bench sweeps every hour value in both modes, every month end of a leap year and of a common year, and the end of February for all one hundred years. It also compares each second of two long runs that cross a century and a leap-day boundary against an arithmetic model.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int BCD_W    = 8;
  localparam int DOW_W    = 3;
  localparam int DOW_LAST = 6;

  typedef logic [BCD_W-1:0] bcd2_t;
  typedef logic [DOW_W-1:0] dow_t;

  localparam bcd2_t CENT_OLD = 8'h19;
  localparam bcd2_t CENT_NEW = 8'h20;

  function automatic logic bcd_ok(bcd2_t v);
    return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
  endfunction

  function automatic bcd2_t bcd_inc(bcd2_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [6:0] bcd_to_bin(bcd2_t v);
    return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(bcd2_t yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return b[1:0] == 2'b00;
  endfunction

  function automatic bcd2_t month_days(bcd2_t mon, bcd2_t yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
  parameter int SUB_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic tick,
  output logic sec_pulse
);

  localparam int PH_W = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

  generate
    if (SUB_DIV == 1) begin : g_direct
      assign sec_pulse = tick && !clr;
    end else begin : g_div
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(SUB_DIV - 1);
      logic [PH_W-1:0] phase;

      always_ff @(posedge clk) begin
        if (rst || clr)       phase <= '0;
        else if (tick)        phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      end

      assign sec_pulse = tick && !clr && (phase == PH_LAST);

      a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_LAST);
      a_r2_phase_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(phase));
      a_r10_phase_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (phase == '0));
    end
  endgenerate

endmodule

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap import rtc_cal_pkg::*; #(
  parameter bcd2_t RST_VAL = 8'h00
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  ld,
  input  bcd2_t ld_val,
  input  logic  inc,
  input  bcd2_t lo,
  input  bcd2_t hi,
  output bcd2_t val,
  output logic  at_hi
);

  assign at_hi = (val >= hi);

  always_ff @(posedge clk) begin
    if (rst)      val <= RST_VAL;
    else if (ld)  val <= ld_val;
    else if (inc) val <= at_hi ? lo : bcd_inc(val);
  end

  a_r12_bcd_digits: assert property (@(posedge clk) disable iff (rst)
    bcd_ok(val));
  a_r12_in_range: assert property (@(posedge clk) disable iff (rst)
    (val >= lo) && (val <= hi));
  a_r3_wrap_low: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && at_hi) |=> (val == $past(lo)));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(val));

endmodule

// File: rtl/rtc_hour_unit.sv
module rtc_hour_unit import rtc_cal_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  ld,
  input  bcd2_t ld_hour,
  input  logic  ld_mode24,
  input  logic  ld_pm,
  input  logic  inc,
  output bcd2_t hour,
  output logic  mode24,
  output logic  pm,
  output logic  day_end
);

  bcd2_t nxt_hour;
  logic  nxt_pm;

  always_comb begin
    nxt_hour = bcd_inc(hour);
    nxt_pm   = pm;
    day_end  = 1'b0;
    if (mode24) begin
      if (hour >= 8'h23) begin
        nxt_hour = 8'h00;
        day_end  = 1'b1;
      end
    end else begin
      if (hour >= 8'h12) begin
        nxt_hour = 8'h01;
      end else if (hour == 8'h11) begin
        nxt_hour = 8'h12;
        nxt_pm   = ~pm;
        day_end  = pm;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hour   <= 8'h12;
      mode24 <= 1'b0;
      pm     <= 1'b0;
    end else if (ld) begin
      hour   <= ld_hour;
      mode24 <= ld_mode24;
      pm     <= ld_mode24 ? 1'b0 : ld_pm;
    end else if (inc) begin
      hour   <= nxt_hour;
      pm     <= nxt_pm;
    end
  end

  a_r4_range24: assert property (@(posedge clk) disable iff (rst)
    mode24 |-> (hour <= 8'h23 && bcd_ok(hour)));
  a_r4_pm_low: assert property (@(posedge clk) disable iff (rst)
    mode24 |-> !pm);
  a_r5_range12: assert property (@(posedge clk) disable iff (rst)
    !mode24 |-> (hour >= 8'h01 && hour <= 8'h12 && bcd_ok(hour)));
  a_r5_pm_flip: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && !mode24 && hour == 8'h11) |=> (pm != $past(pm)));
  a_r5_pm_steady: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && !mode24 && hour != 8'h11) |=> $stable(pm));

endmodule

// File: rtl/rtc_load_check.sv
module rtc_load_check import rtc_cal_pkg::*; (
  input  bcd2_t sec,
  input  bcd2_t min,
  input  bcd2_t hour,
  input  logic  mode24,
  input  bcd2_t date,
  input  bcd2_t month,
  input  bcd2_t year,
  input  bcd2_t century,
  input  dow_t  dow,
  output logic  ok
);

  logic time_ok, hour_ok, cal_ok, misc_ok;

  always_comb begin
    time_ok = bcd_ok(sec) && (sec <= 8'h59) && bcd_ok(min) && (min <= 8'h59);
    hour_ok = bcd_ok(hour) &&
              (mode24 ? (hour <= 8'h23) : (hour >= 8'h01 && hour <= 8'h12));
    cal_ok  = bcd_ok(month) && (month >= 8'h01) && (month <= 8'h12) &&
              bcd_ok(year) && bcd_ok(date) && (date >= 8'h01) &&
              (date <= month_days(month, year));
    misc_ok = ((century == CENT_OLD) || (century == CENT_NEW)) &&
              (dow <= dow_t'(DOW_LAST));
    ok      = time_ok && hour_ok && cal_ok && misc_ok;
  end

endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter import rtc_cal_pkg::*; #(
  parameter int SUB_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_sec,
  input  logic [7:0] wr_min,
  input  logic [7:0] wr_hour,
  input  logic       wr_mode24,
  input  logic       wr_pm,
  input  logic [7:0] wr_date,
  input  logic [7:0] wr_month,
  input  logic [7:0] wr_year,
  input  logic [7:0] wr_century,
  input  logic [2:0] wr_dow,
  output logic [7:0] cur_sec,
  output logic [7:0] cur_min,
  output logic [7:0] cur_hour,
  output logic       cur_mode24,
  output logic       cur_pm,
  output logic [7:0] cur_date,
  output logic [7:0] cur_month,
  output logic [7:0] cur_year,
  output logic [7:0] cur_century,
  output logic [2:0] cur_dow
);

  localparam int N_BASE60 = 2;

  logic  ld_ok, take, adv;
  logic  hour_inc, hour_day_end, day_inc;
  logic  date_hi, month_inc, month_hi, year_inc, year_hi;
  bcd2_t date_len;
  bcd2_t century_q;
  dow_t  dow_q;

  bcd2_t                fld_ld  [N_BASE60];
  bcd2_t                fld_val [N_BASE60];
  logic  [N_BASE60-1:0] fld_inc;
  logic  [N_BASE60-1:0] fld_hi;

  assign wr_ready = 1'b1;
  assign take     = wr_valid && ld_ok;

  rtc_load_check u_check (
    .sec(wr_sec), .min(wr_min), .hour(wr_hour), .mode24(wr_mode24),
    .date(wr_date), .month(wr_month), .year(wr_year),
    .century(wr_century), .dow(wr_dow), .ok(ld_ok)
  );

  rtc_subsec #(.SUB_DIV(SUB_DIV)) u_subsec (
    .clk(clk), .rst(rst), .clr(take), .tick(tick && !take), .sec_pulse(adv)
  );

  assign fld_ld[0] = wr_sec;
  assign fld_ld[1] = wr_min;
  assign fld_inc[0] = adv;
  assign fld_inc[1] = adv && fld_hi[0];

  generate
    for (genvar g = 0; g < N_BASE60; g++) begin : g_base60
      rtc_bcd_wrap #(.RST_VAL(8'h00)) u_fld (
        .clk(clk), .rst(rst), .ld(take), .ld_val(fld_ld[g]), .inc(fld_inc[g]),
        .lo(8'h00), .hi(8'h59), .val(fld_val[g]), .at_hi(fld_hi[g])
      );
    end
  endgenerate

  assign hour_inc = fld_inc[N_BASE60-1] && fld_hi[N_BASE60-1];

  rtc_hour_unit u_hour (
    .clk(clk), .rst(rst), .ld(take), .ld_hour(wr_hour), .ld_mode24(wr_mode24),
    .ld_pm(wr_pm), .inc(hour_inc), .hour(cur_hour), .mode24(cur_mode24),
    .pm(cur_pm), .day_end(hour_day_end)
  );

  assign day_inc   = hour_inc && hour_day_end;
  assign date_len  = month_days(cur_month, cur_year);
  assign month_inc = day_inc && date_hi;
  assign year_inc  = month_inc && month_hi;

  rtc_bcd_wrap #(.RST_VAL(8'h01)) u_date (
    .clk(clk), .rst(rst), .ld(take), .ld_val(wr_date), .inc(day_inc),
    .lo(8'h01), .hi(date_len), .val(cur_date), .at_hi(date_hi)
  );

  rtc_bcd_wrap #(.RST_VAL(8'h01)) u_month (
    .clk(clk), .rst(rst), .ld(take), .ld_val(wr_month), .inc(month_inc),
    .lo(8'h01), .hi(8'h12), .val(cur_month), .at_hi(month_hi)
  );

  rtc_bcd_wrap #(.RST_VAL(8'h00)) u_year (
    .clk(clk), .rst(rst), .ld(take), .ld_val(wr_year), .inc(year_inc),
    .lo(8'h00), .hi(8'h99), .val(cur_year), .at_hi(year_hi)
  );

  always_ff @(posedge clk) begin
    if (rst)                                              century_q <= CENT_NEW;
    else if (take)                                        century_q <= wr_century;
    else if (year_inc && year_hi && century_q == CENT_OLD) century_q <= CENT_NEW;
  end

  always_ff @(posedge clk) begin
    if (rst)          dow_q <= '0;
    else if (take)    dow_q <= wr_dow;
    else if (day_inc) dow_q <= (dow_q >= dow_t'(DOW_LAST)) ? '0 : dow_q + 1'b1;
  end

  assign cur_sec     = fld_val[0];
  assign cur_min     = fld_val[1];
  assign cur_century = century_q;
  assign cur_dow     = dow_q;

  a_r8_century_legal: assert property (@(posedge clk) disable iff (rst)
    (cur_century == CENT_OLD) || (cur_century == CENT_NEW));
  a_r8_century_hold: assert property (@(posedge clk) disable iff (rst)
    (cur_century == CENT_NEW && !take) |=> (cur_century == CENT_NEW));
  a_r9_dow_range: assert property (@(posedge clk) disable iff (rst)
    cur_dow <= dow_t'(DOW_LAST));
  a_r9_dow_quiet: assert property (@(posedge clk) disable iff (rst)
    (!day_inc && !take) |=> $stable(cur_dow));
  a_r7_leap_day: assert property (@(posedge clk) disable iff (rst)
    (cur_month == 8'h02 && cur_date == 8'h29) |-> leap_year(cur_year));
  a_r10_load_all: assert property (@(posedge clk) disable iff (rst)
    take |=> (cur_sec == $past(wr_sec) && cur_min == $past(wr_min) &&
              cur_date == $past(wr_date) && cur_year == $past(wr_year) &&
              cur_dow == $past(wr_dow)));
  a_r11_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !ld_ok && !tick) |=>
      ($stable(cur_sec) && $stable(cur_hour) && $stable(cur_date) &&
       $stable(cur_month) && $stable(cur_century) && $stable(cur_dow)));

endmodule

// File: tb/bcd_calendar_counter_test.sv
`timescale 1ns/1ps
module bcd_calendar_counter_test;

  localparam int SUB = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst, tick, wr_valid, wr_ready, wr_mode24, wr_pm;
  logic [7:0] wr_sec, wr_min, wr_hour, wr_date, wr_month, wr_year, wr_century;
  logic [2:0] wr_dow;
  logic [7:0] cur_sec, cur_min, cur_hour, cur_date, cur_month, cur_year, cur_century;
  logic       cur_mode24, cur_pm;
  logic [2:0] cur_dow;

  bcd_calendar_counter #(.SUB_DIV(SUB)) uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sec(wr_sec), .wr_min(wr_min), .wr_hour(wr_hour), .wr_mode24(wr_mode24),
    .wr_pm(wr_pm), .wr_date(wr_date), .wr_month(wr_month), .wr_year(wr_year),
    .wr_century(wr_century), .wr_dow(wr_dow),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mode24(cur_mode24), .cur_pm(cur_pm), .cur_date(cur_date),
    .cur_month(cur_month), .cur_year(cur_year), .cur_century(cur_century),
    .cur_dow(cur_dow)
  );

  int total = 0;
  int bad   = 0;

  // reference model, binary, hours kept 0..23 in both modes
  int ms, mm, mh, md, mmo, my, mc, mw, mph;
  bit m24;

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic step_model();
    ms++;
    if (ms == 60) begin ms = 0; mm++; end
    if (mm == 60) begin mm = 0; mh++; end
    if (mh == 24) begin
      mh = 0;
      mw = (mw + 1) % 7;
      md++;
      if (md > dim(mmo, my)) begin md = 1; mmo++; end
      if (mmo == 13) begin
        mmo = 1; my++;
        if (my == 100) begin my = 0; if (mc == 19) mc = 20; end
      end
    end
  endtask

  function automatic logic [7:0] exp_hour();
    int h12;
    h12 = (mh % 12 == 0) ? 12 : mh % 12;
    return m24 ? tobcd(mh) : tobcd(h12);
  endfunction

  task automatic check(string tag);
    logic [69:0] got, exp;
    got = {cur_sec, cur_min, cur_hour, cur_mode24, cur_pm, cur_date, cur_month,
           cur_year, cur_century, 1'b0, wr_ready, cur_dow};
    exp = {tobcd(ms), tobcd(mm), exp_hour(), m24, (!m24 && mh >= 12), tobcd(md),
           tobcd(mmo), tobcd(my), tobcd(mc), 1'b0, 1'b1, 3'(mw)};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h (sec min hour mode pm date month year cent rdy dow)",
               tag, got, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    mph++;
    if (mph == SUB) begin mph = 0; step_model(); end
  endtask

  task automatic step_second();
    repeat (SUB) tick_once();
  endtask

  task automatic drive_model();
    wr_sec = tobcd(ms); wr_min = tobcd(mm); wr_hour = exp_hour();
    wr_mode24 = m24; wr_pm = !m24 && mh >= 12;
    wr_date = tobcd(md); wr_month = tobcd(mmo); wr_year = tobcd(my);
    wr_century = tobcd(mc); wr_dow = 3'(mw);
  endtask

  task automatic set_model(bit a24, int h, int mi, int s, int d, int mo, int y, int c, int w);
    m24 = a24; mh = h; mm = mi; ms = s; md = d; mmo = mo; my = y; mc = c; mw = w;
  endtask

  task automatic do_load(bit with_tick);
    @(negedge clk);
    drive_model();
    wr_valid = 1'b1; tick = with_tick;
    @(negedge clk);
    wr_valid = 1'b0; tick = 1'b0;
    mph = 0;
  endtask

  // drive an illegal variant of the model's current fields; model unchanged
  task automatic try_bad(int which);
    @(negedge clk);
    drive_model();
    case (which)
      0:  wr_sec = 8'h60;
      1:  wr_sec = 8'h3A;
      2:  wr_min = 8'h75;
      3:  begin wr_mode24 = 1'b0; wr_hour = 8'h00; end
      4:  begin wr_mode24 = 1'b0; wr_hour = 8'h13; end
      5:  begin wr_mode24 = 1'b1; wr_hour = 8'h24; end
      6:  wr_date = 8'h00;
      7:  begin wr_month = 8'h02; wr_date = 8'h29; wr_year = 8'h21; end
      8:  begin wr_month = 8'h04; wr_date = 8'h31; end
      9:  wr_month = 8'h00;
      10: wr_month = 8'h13;
      11: wr_month = 8'h0A;
      12: wr_year = 8'h9F;
      13: wr_century = 8'h21;
      14: wr_century = 8'h18;
      default: wr_dow = 3'd7;
    endcase
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    total++; bad++;
    $display("FAIL watchdog: got=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; tick = 1'b0; wr_valid = 1'b0;
    set_model(1'b0, 0, 0, 0, 1, 1, 0, 20, 0);
    mph = 0;
    drive_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state");

    // R2: first tick is sub-second only, second tick advances seconds
    tick_once(); check("R2 partial second");
    tick_once(); check("R2 full second");

    // R3 R4 R6 R8 R9: 24h, one hour across Dec 31 99 -> Jan 01 00, century 19 -> 20
    set_model(1'b1, 23, 0, 0, 31, 12, 99, 19, 6);
    do_load(1'b0); check("R10 load 24h");
    for (int i = 0; i < 3605; i++) begin step_second(); check("R3 R4 R6 R8 R9 run"); end

    // R5 R7: 12h, 11 PM Feb 28 of year 03 -> 12 AM Mar 01
    set_model(1'b0, 23, 0, 0, 28, 2, 3, 20, 2);
    do_load(1'b0);
    for (int i = 0; i < 3605; i++) begin step_second(); check("R5 R7 run"); end

    // R5: 11:59:59 AM -> 12:00:00 PM, same day
    set_model(1'b0, 11, 59, 59, 10, 5, 7, 20, 4);
    do_load(1'b0); step_second(); check("R5 noon");

    // R4 R5: every hour value in both modes
    for (int md24 = 0; md24 < 2; md24++) begin
      for (int h = 0; h < 24; h++) begin
        set_model(md24[0], h, 59, 59, 15, 6, 10, 20, h % 7);
        do_load(1'b0); step_second();
        check(md24 == 1 ? "R4 hour sweep" : "R5 hour sweep");
      end
    end

    // R7: end of February for every year, and Feb 29 where legal
    for (int y = 0; y < 100; y++) begin
      set_model(1'b1, 23, 59, 59, 28, 2, y, 20, y % 7);
      do_load(1'b0); step_second(); check("R7 feb 28");
      if (y % 4 == 0) begin
        set_model(1'b0, 23, 59, 59, 29, 2, y, 19, y % 7);
        do_load(1'b0); step_second(); check("R7 feb 29");
      end
    end

    // R6: every month end in a common and a leap year
    for (int k = 0; k < 2; k++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        set_model(1'b1, 23, 59, 59, dim(mo, k == 0 ? 1 : 4), mo, k == 0 ? 1 : 4, 20, mo % 7);
        do_load(1'b0); step_second(); check("R6 month end");
      end
    end

    // R8: century 20 holds across year 99 -> 00
    set_model(1'b1, 23, 59, 59, 31, 12, 99, 20, 5);
    do_load(1'b0); step_second(); check("R8 century hold");

    // R10: write beats a same-cycle tick, and restarts the phase
    tick_once();
    set_model(1'b1, 8, 30, 15, 20, 9, 45, 20, 1);
    do_load(1'b1); check("R10 load over tick");
    tick_once(); check("R10 phase restarted");
    tick_once(); check("R10 second after load");
    tick_once();
    do_load(1'b0); tick_once(); check("R10 phase cleared by write");

    // R11: dropped writes leave fields and phase untouched
    set_model(1'b0, 10, 20, 30, 15, 6, 21, 20, 3);
    do_load(1'b0);
    tick_once();
    for (int b = 0; b < 16; b++) begin try_bad(b); check("R11 dropped write"); end
    tick_once(); check("R11 phase kept");
    set_model(1'b1, 14, 0, 0, 3, 3, 3, 20, 0);
    @(negedge clk); drive_model(); wr_pm = 1'b1; wr_valid = 1'b1;
    @(negedge clk); wr_valid = 1'b0; mph = 0;
    check("R11 pm ignored in 24h");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule